// File: doc/BRIEF.md
# Bitonic Packet Slot Sorter

This block reorders a frame of N = 2^n packet slots into ascending key order. Each slot carries an occupied flag and an unsigned sort key. The key is a destination address, and the caller may prefix it with a routing index in the upper bits. After sorting, the occupied slots sit on the lowest-numbered outputs in non-decreasing key order, and the empty slots gather on the highest-numbered outputs. The result is a compact monotone frame, which is the form a self-routing banyan stage downstream needs to route without internal conflicts.

The network is a Batcher bitonic arrangement of 2x2 compare-exchange cells. It has n(n+1)/2 stages, and each stage holds N/2 cells. Every cell ranks an empty slot above any occupied key. The bitonic schedule decides whether a given cell puts the smaller rank on its lower or its upper lane.

Every slot crosses the same number of stages. With the pipeline option set, one register bank follows each stage. A frame then appears at the output exactly n(n+1)/2 cycles after it is presented, and a new frame can enter on every cycle. With the option cleared, the network is purely combinational.

Top module: `bitonic_slot_sorter`

## Requirements
- R1: After reset, `out_vld` is low and every bit of `out_occ` is low.
- R2: When `out_vld` is high, the keys on occupied outputs are non-decreasing from output 0 upward, compared as unsigned numbers.
- R3: When `out_vld` is high and V input slots were occupied, `out_occ` equals 2^V - 1. Occupied slots fill outputs 0..V-1 and empty slots fill the rest.
- R4: The multiset of keys on occupied outputs equals the multiset of keys on occupied inputs. Duplicate keys are neither lost nor replicated, and equal keys may leave in any relative order.
- R5: The key value of an empty input slot has no effect on `out_occ` or on the keys of occupied outputs.
- R6: With PIPE = 1, a frame presented with `in_vld` high in one cycle appears with `out_vld` high exactly n(n+1)/2 cycles later. `out_vld` is low in the cycle before that. With PIPE = 0, the output follows the input in the same cycle.
- R7: With PIPE = 1, frames presented on consecutive cycles emerge on consecutive cycles, in the same order, each sorted independently.
- R8: The key is compared as a whole. A set upper (routing index) bit outranks any combination of lower bits, so key 4'b1000 sorts after key 4'b0111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Frame present on the slot inputs this cycle |
| in_occ | input | N | Occupied flag per input slot, bit i for slot i |
| in_key | input | N*KEY_W | Keys; slot i at bits [i*KEY_W +: KEY_W] |
| out_vld | output | 1 | Sorted frame present on the outputs |
| out_occ | output | N | Occupied flag per output position |
| out_key | output | N*KEY_W | Sorted keys; position i at bits [i*KEY_W +: KEY_W] |

## Verification
The sorter is driven with a worked example that mixes duplicates and one empty slot, with a fully empty frame, a fully reversed full frame, all-equal keys and an already sorted frame. These frames tell apart a cell with the wrong direction, a lost or duplicated packet, and a schedule that only works for some orderings. A pair of frames that differ only in the keys of their empty slots shows whether empties leak into the order. A frame with upper key bits set checks full-width comparison. Back-to-back frames and a run of pseudo-random frames check latency alignment and per-cycle throughput, and they exercise many cell-direction combinations.

// File: rtl/bitonic_slot_sorter.sv
module bitonic_slot_sorter #(
  parameter int LOG_N = 3,
  parameter int KEY_W = 4,
  parameter bit PIPE  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [(1<<LOG_N)-1:0]       in_occ,
  input  logic [(1<<LOG_N)*KEY_W-1:0] in_key,
  output logic                 out_vld,
  output logic [(1<<LOG_N)-1:0]       out_occ,
  output logic [(1<<LOG_N)*KEY_W-1:0] out_key
);
  localparam int N     = 1 << LOG_N;
  localparam int W     = KEY_W + 1;
  localparam int S     = LOG_N * (LOG_N + 1) / 2;
  localparam int CNT_W = $clog2(S + 1) + 1;
  localparam logic [W-1:0] EMPTY_LANE = {1'b1, {KEY_W{1'b0}}};

  wire [N*W-1:0] bus [0:S];
  wire           vsr [0:S];

  function automatic int empties(input logic [N*W-1:0] v);
    int c;
    c = 0;
    for (int i = 0; i < N; i++) c += int'(v[i*W+KEY_W]);
    return c;
  endfunction

  function automatic bit ranked(input logic [N*W-1:0] v);
    bit ok;
    ok = 1'b1;
    for (int i = 0; i + 1 < N; i++)
      if (v[i*W +: W] > v[(i+1)*W +: W]) ok = 1'b0;
    return ok;
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_in
    assign bus[0][i*W +: W] = {~in_occ[i], in_key[i*KEY_W +: KEY_W]};
    assign out_occ[i] = ~bus[S][i*W+KEY_W];
    assign out_key[i*KEY_W +: KEY_W] = bus[S][i*W +: KEY_W];
  end
  assign vsr[0]  = in_vld;
  assign out_vld = vsr[S];

  for (genvar p = 1; p <= LOG_N; p++) begin : g_phase
    for (genvar t = 0; t < p; t++) begin : g_step
      localparam int SI = p * (p - 1) / 2 + t;
      localparam int J  = 1 << (p - 1 - t);
      localparam int K  = 1 << p;
      logic [N*W-1:0] nxt;

      for (genvar i = 0; i < N; i++) begin : g_lane
        if ((i & J) == 0) begin : g_ce
          localparam int L  = i + J;
          localparam bit UP = ((i & K) == 0);
          logic [W-1:0] a, b;
          logic         swap;
          assign a    = bus[SI][i*W +: W];
          assign b    = bus[SI][L*W +: W];
          assign swap = UP ? (a > b) : (a < b);
          assign nxt[i*W +: W] = swap ? b : a;
          assign nxt[L*W +: W] = swap ? a : b;
        end
      end

      if (PIPE) begin : g_reg
        logic [N*W-1:0] q;
        logic           qv;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            q  <= {N{EMPTY_LANE}};
            qv <= 1'b0;
          end else begin
            q  <= nxt;
            qv <= vsr[SI];
          end
        end
        assign bus[SI+1] = q;
        assign vsr[SI+1] = qv;

        p_count_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
          qv |-> empties(q) == $past(empties(bus[SI])));
      end else begin : g_wire
        assign bus[SI+1] = nxt;
        assign vsr[SI+1] = vsr[SI];
      end
    end
  end

  if (PIPE) begin : g_age
    logic [CNT_W-1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst < CNT_W'(S)) since_rst <= since_rst + 1'b1;
    end
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> since_rst >= CNT_W'(S));
  end else begin : g_flat
    always_comb begin
      if (in_vld) begin
        p_count_kept_r4: assert (empties(bus[S]) == empties(bus[0]));
      end
    end
  end

  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ranked(bus[S]));

  p_empty_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ((out_occ & (out_occ + 1'b1)) == '0));

endmodule

// File: tb/bitonic_slot_sorter_tb.sv
module bitonic_slot_sorter_tb_top;
  localparam int LOG_N = 3;
  localparam int N     = 1 << LOG_N;
  localparam int KW    = 4;
  localparam int S     = LOG_N * (LOG_N + 1) / 2;

  logic clk = 1'b0;
  logic rst_n;
  logic in_vld;
  logic [N-1:0]    in_occ;
  logic [N*KW-1:0] in_key;
  logic            out_vld;
  logic [N-1:0]    out_occ;
  logic [N*KW-1:0] out_key;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  bitonic_slot_sorter #(.LOG_N(LOG_N), .KEY_W(KW), .PIPE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_occ(in_occ), .in_key(in_key),
    .out_vld(out_vld), .out_occ(out_occ), .out_key(out_key));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N*KW-1:0] ref_keys(input logic [N-1:0] occ, input logic [N*KW-1:0] key);
    int v [N];
    int cnt, tmp;
    logic [N*KW-1:0] r;
    cnt = 0;
    for (int i = 0; i < N; i++) if (occ[i]) begin v[cnt] = int'(key[i*KW +: KW]); cnt++; end
    for (int i = 0; i < cnt; i++)
      for (int j = 0; j + 1 < cnt - i; j++)
        if (v[j] > v[j+1]) begin tmp = v[j]; v[j] = v[j+1]; v[j+1] = tmp; end
    r = '0;
    for (int i = 0; i < cnt; i++) r[i*KW +: KW] = KW'(v[i]);
    return r;
  endfunction

  function automatic logic [N-1:0] ref_occ(input logic [N-1:0] occ);
    return N'((1 << $countones(occ)) - 1);
  endfunction

  function automatic logic [N*KW-1:0] mask_keys(input logic [N-1:0] occ, input logic [N*KW-1:0] key);
    logic [N*KW-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) if (occ[i]) r[i*KW +: KW] = key[i*KW +: KW];
    return r;
  endfunction

  task automatic check_frame(input string req, input logic [N-1:0] occ, input logic [N*KW-1:0] key);
    chk({req, " R6 out_vld"}, 64'(out_vld), 64'd1);
    chk({req, " R3 out_occ"}, 64'(out_occ), 64'(ref_occ(occ)));
    chk({req, " R2 R4 keys"}, 64'(mask_keys(out_occ, out_key)), 64'(ref_keys(occ, key)));
  endtask

  task automatic run_vec(input string req, input logic [N-1:0] occ, input logic [N*KW-1:0] key);
    in_occ = occ; in_key = key; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0; in_occ = '0; in_key = '0;
    repeat (S - 2) @(negedge clk);
    chk({req, " R6 early"}, 64'(out_vld), 64'd0);
    @(negedge clk);
    check_frame(req, occ, key);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 out_vld", 64'(out_vld), 64'd0);
    chk("R1 out_occ", 64'(out_occ), 64'd0);
  endtask

  task automatic t_example;
    run_vec("R2 example", 8'b1011_1111,
            {4'd3, 4'd9, 4'd6, 4'd4, 4'd3, 4'd4, 4'd0, 4'd3});
  endtask

  task automatic t_empty_keys_r5;
    logic [N*KW-1:0] ka, kb;
    logic [N-1:0] oc, occ_a;
    logic [N*KW-1:0] key_a;
    oc = 8'b0101_0110;
    ka = {4'd0, 4'd7, 4'd0, 4'd2, 4'd0, 4'd5, 4'd9, 4'd0};
    kb = {4'd15, 4'd7, 4'd15, 4'd2, 4'd1, 4'd5, 4'd9, 4'd15};
    run_vec("R5 empties key0", oc, ka);
    in_occ = oc; in_key = ka; in_vld = 1'b1;
    @(negedge clk);
    in_key = kb;
    @(negedge clk);
    in_vld = 1'b0;
    repeat (S - 2) @(negedge clk);
    occ_a = out_occ; key_a = mask_keys(out_occ, out_key);
    @(negedge clk);
    chk("R5 occ unaffected", 64'(out_occ), 64'(occ_a));
    chk("R5 keys unaffected", 64'(mask_keys(out_occ, out_key)), 64'(key_a));
    @(negedge clk);
  endtask

  task automatic t_back_to_back_r7;
    logic [N-1:0]    o1, o2;
    logic [N*KW-1:0] k1, k2;
    o1 = 8'hFF; k1 = {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8};
    o2 = 8'b1000_0001; k2 = {4'd2, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd1};
    in_occ = o1; in_key = k1; in_vld = 1'b1;
    @(negedge clk);
    in_occ = o2; in_key = k2;
    @(negedge clk);
    in_vld = 1'b0;
    repeat (S - 2) @(negedge clk);
    check_frame("R7 first", o1, k1);
    @(negedge clk);
    check_frame("R7 second", o2, k2);
    @(negedge clk);
    chk("R7 R6 drain", 64'(out_vld), 64'd0);
  endtask

  task automatic t_random(input int count);
    logic [31:0] lf;
    lf = 32'hACE1_2357;
    for (int n = 0; n < count; n++) begin
      logic [N-1:0] o;
      logic [N*KW-1:0] k;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      o = lf[N-1:0];
      for (int i = 0; i < N; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        k[i*KW +: KW] = lf[KW-1:0];
      end
      run_vec("R4 random", o, k);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; in_occ = '0; in_key = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_example();
    run_vec("R3 all empty", 8'h00, {8{4'd5}});
    run_vec("R2 reversed", 8'hFF, {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7});
    run_vec("R4 all equal", 8'hFF, {8{4'd9}});
    run_vec("R2 presorted", 8'hFF, {4'd15, 4'd12, 4'd9, 4'd7, 4'd7, 4'd3, 4'd1, 4'd0});
    run_vec("R8 prefix bit", 8'b0000_1111, {16'h0000, 4'd8, 4'd7, 4'd15, 4'd0});
    t_empty_keys_r5();
    t_back_to_back_r7();
    t_random(40);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule